// File: doc/BRIEF.md
# Shared Interrupt and Output Port Unit

This block holds the registers that two serial channels have in common. Each channel reports two conditions, transmitter ready and receiver ready. The block places these conditions side by side in one status byte, and a mask register decides which of them pull the single active-low interrupt line. Software reads the status byte and serves each set bit. It repeats the read until the masked status is zero.

The same register window also serves the modem pins. Input pins are active low. They pass through a synchronizer, and the block keeps a change flag for each pin. Reading the change register returns the pin levels and the change flags, and the read clears the flags. The output port is never written directly. One address sets the bits that are 1 in the written byte, and another address clears them. A configuration register can hand single output pins to an alternate source. The auxiliary control register carries a baud-set select and a three-bit timer mode, which go to neighbouring logic.

The register interface is a plain single-cycle bus. There is no back-pressure. A write takes effect at the clock edge where `bus_wr` is high. Read data is combinational while `bus_rd` is high, and any side effect of the read happens at that same edge.

Top module: `shared_irq_port_unit`

## Requirements
- R1: After reset, `irq_n` is 1, every `pin_out_n` bit is 1, `aux_baud_set` and `aux_timer_mode` are 0, and the status byte reads 0 while no channel reports a condition.
- R2: Reading address 0x5 returns the status byte. Channel n's transmit-ready input appears at bit 4n and its receive-ready input at bit 4n+1, one clock after the input. All other bits read 0. A bit is not latched: it drops one clock after its input drops.
- R3: Writing address 0x5 loads the mask, using the same bit layout as the status byte. `irq_n` is 0 exactly when the status byte AND the mask is nonzero.
- R4: Writing address 0xE sets every output-port bit that is 1 in the written byte. The other bits keep their values.
- R5: Writing address 0xF clears every output-port bit that is 1 in the written byte. The other bits keep their values.
- R6: Writing address 0xD loads the output configuration. Where a configuration bit is 0, `pin_out_n` for that bit is the inverse of the output-port bit. Where it is 1, the pin copies `alt_out_n`. The reset value of 0 makes every pin follow the port.
- R7: Writing address 0x4 loads the auxiliary control. Written bit 7 drives `aux_baud_set`, and written bits 6:4 drive `aux_timer_mode`.
- R8: Reading address 0x4 returns the synchronized pin levels in bits 3:0 and the change flags in bits 7:4. A level reaches the register two clocks after the pin changes, and its change flag sets one clock after that. The read clears the flags. A flag that sets at the same edge as a read is kept for the next read.
- R9: Reading address 0xD returns the synchronized pin levels in bits 3:0 and zeros above them. This read leaves the change flags untouched.
- R10: Writes to unmapped addresses (for example 0x0 and 0xA) change neither the output pins nor the interrupt. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when no read is active |
| chan_tx_rdy | input | 2 | Transmit-ready condition from each channel |
| chan_rx_rdy | input | 2 | Receive-ready condition from each channel |
| pin_in_n | input | 4 | Active-low input pins |
| alt_out_n | input | 8 | Alternate drive for output pins that the configuration hands over |
| pin_out_n | output | 8 | Active-low output pins |
| irq_n | output | 1 | Active-low interrupt |
| aux_baud_set | output | 1 | Baud-set select from auxiliary control |
| aux_timer_mode | output | 3 | Timer mode from auxiliary control |

## Verification
The interrupt path is driven from a table of source and mask combinations. Some rows raise a single source in each bit position, which separates the transmit bits from the receive bits and channel 0 from channel 1. Some rows hide a set status bit behind the mask. Other rows make a source drop right after it was high, which shows that status is not latched. The output port runs a sequence of overlapping set and clear bytes, and the alternate-drive configuration is tried with both polarities of the alternate source. The input side pairs destructive reads with non-destructive reads, and it places one pin change exactly on the edge of a read, which tests whether a new change wins over the clear.

// File: rtl/sio_shared_pkg.sv
package sio_shared_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] ADR_AUX   = 4'h4;  // wr: aux control, rd: input change
  localparam logic [ADDR_W-1:0] ADR_IRQ   = 4'h5;  // wr: mask, rd: status
  localparam logic [ADDR_W-1:0] ADR_OCFG  = 4'hD;  // wr: output config, rd: input levels
  localparam logic [ADDR_W-1:0] ADR_OSET  = 4'hE;  // wr: set output bits
  localparam logic [ADDR_W-1:0] ADR_OCLR  = 4'hF;  // wr: clear output bits

  typedef struct packed {
    logic       baud_set;
    logic [2:0] timer_mode;
  } aux_ctrl_t;
endpackage

// File: rtl/sirq_collect.sv
module sirq_collect #(
  parameter int NUM_CH    = 2,
  parameter int CH_STRIDE = 4,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] tx_rdy,
  input  logic [NUM_CH-1:0] rx_rdy,
  input  logic              mask_we,
  input  logic [DATA_W-1:0] mask_wdata,
  output logic [DATA_W-1:0] status_o,
  output logic              irq_n
);
  logic [DATA_W-1:0] status_next, status_q, mask_q;

  // place each channel's events at its stride
  always_comb begin
    status_next = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      status_next[c*CH_STRIDE]     = tx_rdy[c];
      status_next[c*CH_STRIDE + 1] = rx_rdy[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= status_next;
      if (mask_we) mask_q <= mask_wdata;
    end
  end

  assign status_o = status_q;
  assign irq_n    = ~|(status_q & mask_q);

  // R3: clearing the mask silences the line on the next cycle
  a_r3_zero_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && mask_wdata == '0) |=> irq_n);
  // R3: a low line always has some mask bit behind it
  a_r3_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (mask_q != '0));
  // R2: status drops one cycle after all sources drop
  a_r2_not_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_rdy == '0 && rx_rdy == '0) |=> (status_q == '0));
endmodule

// File: rtl/sin_change.sv
module sin_change #(
  parameter int IN_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IN_W-1:0] pin_n,
  input  logic            rd_clear,
  output logic [IN_W-1:0] level_o,
  output logic [IN_W-1:0] delta_o
);
  logic [IN_W-1:0] seen_q, delta_q, chg;

  for (genvar p = 0; p < IN_W; p++) begin : g_pin
    logic [SYNC_STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[SYNC_STAGES-2:0], pin_n[p]};
    end
    assign level_o[p] = chain_q[SYNC_STAGES-1];
  end

  assign chg = level_o ^ seen_q;

  // a new change wins over a clearing read in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= '1;
      delta_q <= '0;
    end else begin
      seen_q  <= level_o;
      delta_q <= (rd_clear ? '0 : delta_q) | chg;
    end
  end

  assign delta_o = delta_q;

  // R8: a read with no fresh change empties the flags
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clear && chg == '0) |=> (delta_o == '0));
  // R8: a detected change is always recorded
  a_r8_change_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (chg != '0) |=> (delta_o != '0));
endmodule

// File: rtl/sout_port.sv
module sout_port #(
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic             cfg_we,
  input  logic [OUT_W-1:0] wdata,
  input  logic [OUT_W-1:0] alt_n,
  output logic [OUT_W-1:0] pin_n
);
  logic [OUT_W-1:0] opr_q, cfg_q, set_mask, clr_mask;

  assign set_mask = set_we ? wdata : '0;
  assign clr_mask = clr_we ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opr_q <= '0;
      cfg_q <= '0;
    end else begin
      opr_q <= (opr_q | set_mask) & ~clr_mask;
      if (cfg_we) cfg_q <= wdata;
    end
  end

  for (genvar b = 0; b < OUT_W; b++) begin : g_drv
    assign pin_n[b] = cfg_q[b] ? alt_n[b] : ~opr_q[b];
  end

  // R4: written ones are present after a set write
  a_r4_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((opr_q & $past(wdata)) == $past(wdata)));
  // R5: written ones are gone after a clear write
  a_r5_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((opr_q & $past(wdata)) == '0));
  // R6/R10: no other access moves the port
  a_r10_port_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_we || clr_we) |=> $stable(opr_q));
endmodule

// File: rtl/shared_irq_port_unit.sv
module shared_irq_port_unit
  import sio_shared_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int CH_STRIDE   = 4,
  parameter int IN_W        = 4,
  parameter int OUT_W       = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] chan_tx_rdy,
  input  logic [NUM_CH-1:0] chan_rx_rdy,
  input  logic [IN_W-1:0]   pin_in_n,
  input  logic [OUT_W-1:0]  alt_out_n,
  output logic [OUT_W-1:0]  pin_out_n,
  output logic              irq_n,
  output logic              aux_baud_set,
  output logic [2:0]        aux_timer_mode
);
  localparam int IPC_W = 2 * IN_W;

  logic wr_aux, wr_irq, wr_ocfg, wr_oset, wr_oclr, rd_ipc;
  logic [DATA_W-1:0] status;
  logic [IN_W-1:0]   in_level, in_delta;
  aux_ctrl_t         aux_q;

  assign wr_aux  = bus_wr && bus_addr == ADR_AUX;
  assign wr_irq  = bus_wr && bus_addr == ADR_IRQ;
  assign wr_ocfg = bus_wr && bus_addr == ADR_OCFG;
  assign wr_oset = bus_wr && bus_addr == ADR_OSET;
  assign wr_oclr = bus_wr && bus_addr == ADR_OCLR;
  assign rd_ipc  = bus_rd && bus_addr == ADR_AUX;

  sirq_collect #(.NUM_CH(NUM_CH), .CH_STRIDE(CH_STRIDE), .DATA_W(DATA_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .tx_rdy(chan_tx_rdy), .rx_rdy(chan_rx_rdy),
    .mask_we(wr_irq), .mask_wdata(bus_wdata), .status_o(status), .irq_n(irq_n));

  sin_change #(.IN_W(IN_W), .SYNC_STAGES(SYNC_STAGES)) u_in (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_in_n), .rd_clear(rd_ipc),
    .level_o(in_level), .delta_o(in_delta));

  sout_port #(.OUT_W(OUT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .set_we(wr_oset), .clr_we(wr_oclr),
    .cfg_we(wr_ocfg), .wdata(bus_wdata[OUT_W-1:0]), .alt_n(alt_out_n),
    .pin_n(pin_out_n));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      aux_q <= '0;
    else if (wr_aux) aux_q <= bus_wdata[7:4];
  end

  assign aux_baud_set   = aux_q.baud_set;
  assign aux_timer_mode = aux_q.timer_mode;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        ADR_AUX:  bus_rdata = DATA_W'(IPC_W'({in_delta, in_level}));
        ADR_IRQ:  bus_rdata = status;
        ADR_OCFG: bus_rdata = DATA_W'(in_level);
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R7: aux fields follow the written byte
  a_r7_aux_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_aux |=> (aux_timer_mode == $past(bus_wdata[6:4]) &&
                aux_baud_set == $past(bus_wdata[7])));
  // R10: an idle bus returns zero
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == '0));
endmodule

// File: tb/shared_irq_port_unit_test.sv
`timescale 1ns/1ps
module shared_irq_port_unit_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       bus_wr = 0, bus_rd = 0;
  logic [3:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [1:0] chan_tx_rdy = 0, chan_rx_rdy = 0;
  logic [3:0] pin_in_n = 4'hF;
  logic [7:0] alt_out_n = 8'hFF, pin_out_n;
  logic       irq_n, aux_baud_set;
  logic [2:0] aux_timer_mode;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  shared_irq_port_unit uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .chan_tx_rdy(chan_tx_rdy), .chan_rx_rdy(chan_rx_rdy), .pin_in_n(pin_in_n),
    .alt_out_n(alt_out_n), .pin_out_n(pin_out_n), .irq_n(irq_n),
    .aux_baud_set(aux_baud_set), .aux_timer_mode(aux_timer_mode));

  // {tx[1:0], rx[1:0], mask[7:0], exp_status[7:0], exp_irq_n}
  localparam int NV = 9;
  localparam logic [20:0] VEC [NV] = '{
    {2'b01, 2'b00, 8'h01, 8'h01, 1'b0},
    {2'b00, 2'b01, 8'h01, 8'h02, 1'b1},
    {2'b10, 2'b00, 8'h10, 8'h10, 1'b0},
    {2'b00, 2'b10, 8'h10, 8'h20, 1'b1},
    {2'b00, 2'b10, 8'h20, 8'h20, 1'b0},
    {2'b11, 2'b11, 8'hCC, 8'h33, 1'b1},
    {2'b11, 2'b11, 8'hFF, 8'h33, 1'b0},
    {2'b00, 2'b00, 8'hFF, 8'h00, 1'b1},
    {2'b10, 2'b01, 8'h02, 8'h12, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq_n", {7'b0, irq_n}, 8'h01);
    check("R1 pins", pin_out_n, 8'hFF);
    check("R1 aux", {4'b0, aux_baud_set, aux_timer_mode}, 8'h00);
    rd(4'h5, r); check("R1 status", r, 8'h00);

    // R2/R3 table walk
    for (int i = 0; i < NV; i++) begin
      chan_tx_rdy = VEC[i][20:19];
      chan_rx_rdy = VEC[i][18:17];
      wr(4'h5, VEC[i][16:9]);
      rd(4'h5, r);
      check("R2 status layout", r, VEC[i][8:1]);
      check("R3 irq_n", {7'b0, irq_n}, {7'b0, VEC[i][0]});
    end
    chan_tx_rdy = 0; chan_rx_rdy = 0;
    wr(4'h5, 8'h00);

    // R4 set, R5 clear
    wr(4'hE, 8'h81); check("R4 set", pin_out_n, 8'h7E);
    wr(4'hE, 8'h04); check("R4 set keeps", pin_out_n, 8'h7A);
    wr(4'hF, 8'h80); check("R5 clear", pin_out_n, 8'hFA);

    // R10 unmapped accesses
    wr(4'h0, 8'hFF); wr(4'hA, 8'hFF);
    check("R10 pins", pin_out_n, 8'hFA);
    check("R10 irq", {7'b0, irq_n}, 8'h01);
    rd(4'h2, r); check("R10 read", r, 8'h00);

    // R6 alternate drive
    alt_out_n = 8'h00;
    wr(4'hD, 8'h03); check("R6 alt low", pin_out_n, 8'hF8);
    alt_out_n = 8'hFF; #1;
    check("R6 alt high", pin_out_n, 8'hFB);
    wr(4'hD, 8'h00); check("R6 follow", pin_out_n, 8'hFA);

    // R7 aux control
    wr(4'h4, 8'hE5);
    check("R7 aux", {4'b0, aux_baud_set, aux_timer_mode}, 8'h0E);
    wr(4'h4, 8'h30);
    check("R7 aux2", {4'b0, aux_baud_set, aux_timer_mode}, 8'h03);

    // R8 change register
    rd(4'h4, r); check("R8 idle", r, 8'h0F);
    pin_in_n = 4'hA; repeat (5) @(negedge clk);
    rd(4'h4, r); check("R8 deltas", r, 8'h5A);
    rd(4'h4, r); check("R8 cleared", r, 8'h0A);
    // R9 non-destructive read
    pin_in_n = 4'h8; repeat (5) @(negedge clk);
    rd(4'hD, r); check("R9 levels", r, 8'h08);
    rd(4'hD, r); check("R9 levels again", r, 8'h08);
    rd(4'h4, r); check("R9 flags kept", r, 8'h28);
    rd(4'h4, r); check("R8 cleared2", r, 8'h08);
    // R8 change landing on the read edge
    pin_in_n = 4'hC;
    @(posedge clk); @(posedge clk);
    rd(4'h4, r); check("R8 edge read", r, 8'h0C);
    rd(4'h4, r); check("R8 set wins", r, 8'h4C);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule